// File: doc/BRIEF.md
# Credit-Gated Datagram Transmitter

This block assembles the device-to-host byte stream from a set of payload sources. A source raises its request with the payload byte count already on its length bus. The block picks one requester, writes a three-field header and then passes that source's payload bytes through to the single output byte port. The three header fields are the endpoint number, the receive credits being handed back, and the payload length, each written as unsigned LEB128. Every datagram goes out as one unbroken byte sequence, and `out_last` marks its final byte.

Flow control works with credits in both directions. A transmit credit counter starts at a build-time value, and each datagram the block starts spends one credit from it. The counter goes up by the amount the host returns on `tx_add`. When the counter is zero, nothing new starts. In the other direction, each `rx_free` pulse stands for one received datagram that has been fully processed. These pulses build up a pending count. That count rides back to the host in the credit field of the next data datagram. If no source is waiting, the block sends a credit-only datagram instead, with zero length. A zero-length datagram from a source always carries a zero credit field, so the host never takes it for a credit return.

The controller has five states. IDLE waits to start a datagram. EP, CRED and LEN each send one header field, byte by byte. DATA forwards the payload. The transitions are: start (IDLE to EP, when a transmit credit is available and there is either a requester or pending credit), ep_done (EP to CRED), cred_done (CRED to LEN), len_empty (LEN to IDLE, when the length is zero), len_done (LEN to DATA), and pay_done (DATA to IDLE, on the last payload byte).

Top module: `credit_dgram_tx`

## Requirements
- R1: Every datagram begins with three header fields in this order: endpoint, credit, length. Each field is unsigned LEB128: the low 7 bits go in the first byte, and bit 7 is set on every byte of a field except its last. The payload bytes follow the header.
- R2: A datagram from source i carries endpoint EP_BASE+i (default 126, so source 2 needs two bytes: 0x80 0x01). A credit-only datagram carries endpoint CTRL_EP (default 0).
- R3: Starting a datagram spends one transmit credit. While the count is zero, no datagram starts. A `tx_add_valid` cycle adds `tx_add` to the count, and stalled traffic then goes out.
- R4: After reset the transmit credit count equals TX_CRED_INIT (default 3), and all outputs are idle.
- R5: Each `rx_free` pulse adds one to the pending credit count. A data datagram with nonzero length carries the pending count as sampled at its start. Only that sampled amount is removed from the pending count, and this happens when the last credit byte is accepted. Pulses that arrive later stay for a later datagram.
- R6: With pending credit, an available transmit credit and no requesting source, the block sends endpoint CTRL_EP, the pending count, length 0, and no payload.
- R7: A zero-length datagram from a source carries credit 0 and leaves the pending count untouched.
- R8: Requesters are served in round-robin order, starting after the last granted source. A grant (`src_grant`, one-hot) stays fixed until that datagram's last byte.
- R9: Payload bytes move on `src_valid`/`out_ready`. `out_last` is high on the final payload byte, or on the final length byte when the length is 0, and only together with `out_valid`.
- R10: A header byte stays on `out_data` with `out_valid` high until `out_ready` takes it.
- R11: `src_ready` is never high for a source that does not hold the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Per-source request, held until granted |
| src_len | input | N_SRC*LEN_W | Per-source payload length, valid with request |
| src_valid | input | N_SRC | Per-source payload byte valid |
| src_data | input | N_SRC*8 | Per-source payload byte |
| src_ready | output | N_SRC | Payload byte taken from the granted source |
| src_grant | output | N_SRC | One-hot grant for the current datagram |
| rx_free | input | 1 | One received datagram processed, frees one credit |
| tx_add_valid | input | 1 | Transmit credits returned by host |
| tx_add | input | CRED_W | Number of transmit credits returned |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the datagram |

## Verification
The hardest case to reach is a credit field that differs from the number of `rx_free` pulses seen so far. Pulses have to land after a datagram has sampled its credit value but before that value is cleared. Also, any spare transmit credit makes the block send pending credit at once, so it cannot build up. The stimulus gets around this in two ways. It sends pulses in the middle of a long payload from a two-byte endpoint. It also sends pulses while the transmit credits are used up, so that a zero-length source datagram and the following credit-only datagram compete once credits come back. Round-robin order is checked by raising all three requests while the block is stalled, then releasing credits together, under random downstream back-pressure.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EP,
        ST_CRED,
        ST_LEN,
        ST_DATA
    } dgt_state_e;
endpackage

// File: rtl/dgt_rr_arb.sv
module dgt_rr_arb #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          pick_valid,
    output logic [IW-1:0] pick_idx
);
    logic [IW-1:0] ptr;
    int j;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        j          = 0;
        for (int k = N - 1; k >= 0; k--) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (req[j]) begin
                pick_valid = 1'b1;
                pick_idx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv && pick_valid)
            ptr <= (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
    end
endmodule

// File: rtl/dgt_leb_byte.sv
module dgt_leb_byte #(
    parameter int VAL_W = 12
) (
    input  logic [VAL_W-1:0] rem,
    output logic [7:0]       byte_o,
    output logic             final_o
);
    always_comb begin
        final_o = ((rem >> 7) == '0);
        byte_o  = {~final_o, rem[6:0]};
    end
endmodule

// File: rtl/dgt_credit_book.sv
module dgt_credit_book #(
    parameter int CRED_W       = 8,
    parameter int TX_CRED_INIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_add_valid,
    input  logic [CRED_W-1:0] tx_add,
    input  logic              tx_take,
    input  logic              rx_free,
    input  logic              rx_clear,
    input  logic [CRED_W-1:0] rx_clear_amt,
    output logic [CRED_W-1:0] tx_cnt,
    output logic [CRED_W-1:0] rx_pend
);
    logic [CRED_W-1:0] add_amt;
    logic [CRED_W-1:0] sub_amt;

    always_comb begin
        add_amt = tx_add_valid ? tx_add : '0;
        sub_amt = rx_clear ? rx_clear_amt : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt  <= CRED_W'(TX_CRED_INIT);
            rx_pend <= '0;
        end else begin
            tx_cnt  <= tx_cnt + add_amt - CRED_W'(tx_take);
            rx_pend <= rx_pend + CRED_W'(rx_free) - sub_amt;
        end
    end
endmodule

// File: rtl/credit_dgram_tx.sv
module credit_dgram_tx #(
    parameter int N_SRC        = 3,
    parameter int LEN_W        = 12,
    parameter int CRED_W       = 8,
    parameter int EP_W         = 8,
    parameter int EP_BASE      = 126,
    parameter int CTRL_EP      = 0,
    parameter int TX_CRED_INIT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       src_req,
    input  logic [N_SRC*LEN_W-1:0] src_len,
    input  logic [N_SRC-1:0]       src_valid,
    input  logic [N_SRC*8-1:0]     src_data,
    output logic [N_SRC-1:0]       src_ready,
    output logic [N_SRC-1:0]       src_grant,
    input  logic                   rx_free,
    input  logic                   tx_add_valid,
    input  logic [CRED_W-1:0]      tx_add,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [7:0]             out_data,
    output logic                   out_last
);
    import dgt_pkg::*;

    localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int MX1   = (EP_W > CRED_W) ? EP_W : CRED_W;
    localparam int VAL_W = (MX1 > LEN_W) ? MX1 : LEN_W;

    dgt_state_e        state, state_nx;
    logic [IW-1:0]     sel;
    logic              is_src;
    logic [LEN_W-1:0]  len_q;
    logic [CRED_W-1:0] cred_q;
    logic [LEN_W-1:0]  byte_cnt;
    logic [VAL_W-1:0]  rem;

    logic              pick_valid;
    logic [IW-1:0]     pick_idx;
    logic [CRED_W-1:0] tx_cnt;
    logic [CRED_W-1:0] rx_pend;
    logic              tx_avail;
    logic              start;
    logic              hs;
    logic [7:0]        leb_byte;
    logic              leb_final;
    logic              field_done;
    logic [LEN_W-1:0]  pick_len;

    dgt_rr_arb #(.N(N_SRC), .IW(IW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (src_req),
        .adv        (start),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    dgt_leb_byte #(.VAL_W(VAL_W)) u_leb (
        .rem     (rem),
        .byte_o  (leb_byte),
        .final_o (leb_final)
    );

    dgt_credit_book #(.CRED_W(CRED_W), .TX_CRED_INIT(TX_CRED_INIT)) u_book (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_add_valid (tx_add_valid),
        .tx_add       (tx_add),
        .tx_take      (start),
        .rx_free      (rx_free),
        .rx_clear     ((state == ST_CRED) && field_done),
        .rx_clear_amt (cred_q),
        .tx_cnt       (tx_cnt),
        .rx_pend      (rx_pend)
    );

    always_comb begin
        tx_avail   = (tx_cnt != '0);
        start      = (state == ST_IDLE) && tx_avail && (pick_valid || (rx_pend != '0));
        hs         = out_valid && out_ready;
        field_done = hs && leb_final;
        pick_len   = src_len[pick_idx*LEN_W +: LEN_W];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, ep_done, cred_done, len_empty, len_done, pay_done
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)      state_nx = ST_EP;
            ST_EP:   if (field_done) state_nx = ST_CRED;
            ST_CRED: if (field_done) state_nx = ST_LEN;
            ST_LEN:  if (field_done) state_nx = (len_q == '0) ? ST_IDLE : ST_DATA;
            ST_DATA: if (hs && byte_cnt == LEN_W'(1)) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel      <= '0;
            is_src   <= 1'b0;
            len_q    <= '0;
            cred_q   <= '0;
            byte_cnt <= '0;
            rem      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    sel    <= pick_idx;
                    is_src <= pick_valid;
                    len_q  <= pick_valid ? pick_len : '0;
                    cred_q <= (pick_valid && pick_len == '0) ? '0 : rx_pend;
                    rem    <= pick_valid ? (VAL_W'(EP_BASE) + VAL_W'(pick_idx))
                                         : VAL_W'(CTRL_EP);
                end
                ST_EP: if (hs)
                    rem <= leb_final ? VAL_W'(cred_q) : (rem >> 7);
                ST_CRED: if (hs)
                    rem <= leb_final ? VAL_W'(len_q) : (rem >> 7);
                ST_LEN: if (hs) begin
                    rem <= rem >> 7;
                    if (leb_final) byte_cnt <= len_q;
                end
                ST_DATA: if (hs)
                    byte_cnt <= byte_cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        src_ready = '0;
        src_grant = '0;
        if (state != ST_IDLE && is_src) src_grant[sel] = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_EP, ST_CRED: begin
                out_valid = 1'b1;
                out_data  = leb_byte;
            end
            ST_LEN: begin
                out_valid = 1'b1;
                out_data  = leb_byte;
                out_last  = leb_final && (len_q == '0);
            end
            ST_DATA: begin
                out_valid      = src_valid[sel];
                out_data       = src_data[sel*8 +: 8];
                out_last       = src_valid[sel] && (byte_cnt == LEN_W'(1));
                src_ready[sel] = out_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dgt_tx_chk.sv
module dgt_tx_chk #(
    parameter int N_SRC  = 3,
    parameter int CRED_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input dgt_pkg::dgt_state_e state,
    input logic [CRED_W-1:0]  tx_cnt,
    input logic               tx_add_valid,
    input logic [N_SRC-1:0]   src_grant,
    input logic [N_SRC-1:0]   src_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [7:0]         out_data,
    input logic               out_last
);
    import dgt_pkg::*;

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_grant));

    p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_grant != '0 && !(out_valid && out_ready && out_last)) |=> $stable(src_grant));

    p_ready_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready & ~src_grant) == '0);

    p_hdr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != ST_DATA) |=> (out_valid && $stable(out_data)));

    p_no_credit_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_cnt == '0 && !tx_add_valid) |=> state == ST_IDLE);

    p_credit_spend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !tx_add_valid) |=>
            ((state == ST_EP) ? (tx_cnt == CRED_W'($past(tx_cnt) - 1'b1))
                              : (tx_cnt == $past(tx_cnt))));

    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind credit_dgram_tx dgt_tx_chk #(.N_SRC(N_SRC), .CRED_W(CRED_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .tx_cnt       (tx_cnt),
    .tx_add_valid (tx_add_valid),
    .src_grant    (src_grant),
    .src_ready    (src_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last)
);

// File: tb/credit_dgram_tx_test.sv
module credit_dgram_tx_test;
    localparam int N     = 3;
    localparam int LEN_W = 12;
    localparam int CW    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     src_req;
    logic [N*LEN_W-1:0] src_len;
    logic [N-1:0]     src_valid;
    logic [N*8-1:0]   src_data;
    logic [N-1:0]     src_ready;
    logic [N-1:0]     src_grant;
    logic             rx_free = 1'b0;
    logic             tx_add_valid = 1'b0;
    logic [CW-1:0]    tx_add = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             out_last;

    int checks = 0;
    int fails  = 0;
    logic [8:0] expq[$];
    int issued[N];
    int served[N];
    int len_a[N];
    int scnt[N];
    logic [N-1:0] prev_g = '0;
    logic stall_mode = 1'b0;
    logic sv_en = 1'b1;
    logic [7:0] lfsr = 8'h5A;
    logic done = 1'b0;

    always #4 clk = ~clk;

    credit_dgram_tx uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_len(src_len),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .src_grant(src_grant), .rx_free(rx_free), .tx_add_valid(tx_add_valid),
        .tx_add(tx_add), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    for (genvar i = 0; i < N; i++) begin : g_src
        assign src_req[i]                 = (issued[i] != served[i]);
        assign src_len[i*LEN_W +: LEN_W]  = LEN_W'(len_a[i]);
        assign src_valid[i]               = src_grant[i] & sv_en;
        assign src_data[i*8 +: 8]         = 8'(i * 64 + scnt[i]);
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            issued[i] = 0; served[i] = 0; len_a[i] = 0; scnt[i] = 0;
        end
    end

    // source model: counts accepted bytes, retires a request once granted
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!src_grant[i]) scnt[i] <= 0;
            else if (src_valid[i] && src_ready[i]) scnt[i] <= scnt[i] + 1;
            if (src_grant[i] && !prev_g[i]) served[i] <= served[i] + 1;
        end
        prev_g <= src_grant;
    end

    // back-pressure driver
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
        sv_en     = stall_mode ? (lfsr[1] | lfsr[5]) : 1'b1;
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && !done) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R3/R6 unexpected byte: actual %02h last=%0d, expected none",
                         out_data, out_last);
            end else begin
                logic [8:0] e;
                e = expq.pop_front();
                if ({out_last, out_data} !== e) begin
                    fails++;
                    $display("FAIL R1/R2/R5/R9 stream byte: actual %02h last=%0d, expected %02h last=%0d",
                             out_data, out_last, e[7:0], e[8]);
                end
            end
        end
    end

    task automatic push_leb(int v, bit fin);
        int x = v;
        do begin
            logic [6:0] b = 7'(x);
            x = x >> 7;
            expq.push_back({fin && (x == 0), (x != 0), b});
        end while (x != 0);
    endtask

    // R1: header endpoint, credit, length in LEB128, then payload
    task automatic exp_dgram(int ep, int cred, int len, int src);
        push_leb(ep, 1'b0);
        push_leb(cred, 1'b0);
        push_leb(len, len == 0);
        for (int k = 0; k < len; k++)
            expq.push_back({(k == len - 1), 8'(src * 64 + k)});
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic issue(int i, int len);
        len_a[i]  = len;
        issued[i] = issued[i] + 1;
    endtask

    task automatic free_pulse(int n);
        rx_free = 1'b1;
        cyc(n);
        rx_free = 1'b0;
    endtask

    task automatic give_tx(int n);
        tx_add_valid = 1'b1;
        tx_add = CW'(n);
        cyc(1);
        tx_add_valid = 1'b0;
        tx_add = '0;
    endtask

    task automatic drain(string tag);
        for (int k = 0; k < 5000 && expq.size() != 0; k++) cyc(1);
        cyc(4);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s missing bytes: actual %0d left, expected 0", tag, expq.size());
        end
    endtask

    task automatic quiet_check(string tag, int n);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        cyc(1);
        checks++;
        if (seen != 0) begin
            fails++;
            $display("FAIL %s output while out of credits: actual %0d, expected 0", tag, seen);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(5);
        // R4: reset state
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || src_ready !== '0 || src_grant !== '0) begin
            fails++;
            $display("FAIL R4 reset outputs: actual v=%0d rdy=%b g=%b, expected 0",
                     out_valid, src_ready, src_grant);
        end
        rst_n = 1'b1;
        cyc(2);

        // R1 R2 R9: single short datagram, no pending credit
        exp_dgram(126, 0, 3, 0);
        issue(0, 3);
        drain("R1");

        stall_mode = 1'b1;
        // R2: two-byte endpoint, long payload under back-pressure (R10)
        exp_dgram(128, 0, 200, 2);
        issue(2, 200);
        cyc(6);
        // R5: credits freed mid-payload ride the next data datagram, R8 order 0 then 1
        exp_dgram(126, 3, 2, 0);
        free_pulse(3);
        issue(0, 2);
        issue(1, 1);
        drain("R5");

        // R3 R4: three datagrams spent the initial credits, source 1 must wait
        quiet_check("R3", 20);
        free_pulse(1);
        quiet_check("R3", 10);
        exp_dgram(127, 1, 1, 1);
        give_tx(3);
        drain("R3");

        // R6: two back-to-back frees give two credit-only datagrams
        exp_dgram(0, 1, 0, 0);
        exp_dgram(0, 1, 0, 0);
        free_pulse(2);
        drain("R6");

        // R7: zero-length source datagram carries credit 0, pending stays for credit-only
        free_pulse(1);
        issue(1, 0);
        cyc(3);
        exp_dgram(127, 0, 0, 1);
        exp_dgram(0, 1, 0, 0);
        give_tx(2);
        drain("R7");

        // R8: all three request at once, rotation resumes after source 1
        issue(0, 1);
        issue(1, 1);
        issue(2, 1);
        cyc(3);
        exp_dgram(128, 0, 1, 2);
        exp_dgram(126, 0, 1, 0);
        exp_dgram(127, 0, 1, 1);
        give_tx(3);
        drain("R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule